// File: doc/BRIEF.md
# Multi-Source XOR Parity Accumulator

This block folds several equal-length source blocks together with bitwise XOR and keeps the running result in an internal scratchpad. That scratchpad is sized for the largest supported block. A single 32-bit request word configures each job. The word sets the block length, the number of sources, whether the scratchpad starts fresh or continues from earlier content, whether the result is streamed out, and whether the job is an encode or a validate.

Source data enters as a stream of 32-bit words, one word per cycle while the block accepts input. A flag marks the words of the final source. In encode mode the finished parity block can be streamed out word by word. In validate mode no data leaves the block: the job ends with a status word that says whether the XOR of all sources was zero at every position. Every job, including a rejected request, ends with a one-cycle done pulse that carries the status word.

Top module: `xor_parity_acc`

## Requirements
- R1: After reset, req_ready is 1, src_ready is 0, out_valid is 0 and done is 0.
- R2: A request is rejected when any of these holds: request bit 9 (operation type) is 0, the size code in bits 13:11 is greater than 4, or the source count in bits 8:4 is 0. On a rejected request, done pulses in the cycle after acceptance with status 0x4, and no source word is accepted.
- R3: When request bit 1 (emit) is 1 and bit 2 (mode) is 0 (encode), the block streams W = 64 << code words after the last source. Code 0..4 selects 256..4096 bytes. Word i is the XOR of word i of every source, and out_last is set only on word W-1.
- R4: When request bit 0 (fresh) is 1, the first source overwrites the scratchpad. When bit 0 is 0, the first source is XORed into whatever the scratchpad already holds.
- R5: When request bit 2 is 1 (validate), no output word is produced, even if bit 1 is set. Status bit 0 is 1 exactly when some word of the final XOR is nonzero.
- R6: In encode mode with bit 1 clear, no output word is produced, and the status is 0 apart from bit 1.
- R7: Status bit 1 is set when src_last, sampled on the final word of any source, differs from whether that source is the last one counted by bits 8:4.
- R8: With streaming, done pulses in the cycle after the word that carries out_last. Without streaming, done is visible in the cycle after the final source word is accepted.
- R9: src_ready is 1 only while sources are being accumulated, and req_ready is 1 only when no job is active. A source word offered while src_ready is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word present |
| req_word | input | 32 | Packed job configuration |
| req_ready | output | 1 | Block idle, request taken when valid |
| src_valid | input | 1 | Source word present |
| src_data | input | 32 | Source word |
| src_last | input | 1 | Word belongs to the final source |
| src_ready | output | 1 | Source word taken when valid |
| out_valid | output | 1 | Parity word valid |
| out_data | output | 32 | Parity word |
| out_last | output | 1 | Final parity word |
| done | output | 1 | One-cycle job completion pulse |
| status | output | 32 | Job status, valid with done |

## Verification
The bench goes after the following corner cases:
- **Continuation job.** A design that always clears the scratchpad would return only the new sources. This case is preceded by idle-time source words, so a design that accepts input outside a job would corrupt the result.
- **Validate job built to cancel to zero.** Paired with a nonzero one. A zero check that looks at a single source, or that ignores the final word, reports the wrong bit.
- **Misplaced or missing last flags.** These must set the flag error. A design that ends a job on the flag instead of the count would also drop output.
- **Invalid requests.** Each rejection reason gets its own request, so a decoder that checks only one field fails the others.
- **Largest block size.** This exercises the full scratchpad depth and the highest address bit.

// File: rtl/xpa_pkg.sv
package xpa_pkg;
    localparam int REQ_W     = 32;
    localparam int CNT_W     = 5;
    localparam int CODE_W    = 3;
    localparam int STAT_W    = 3;
    localparam int FRESH_BIT = 0;
    localparam int EMIT_BIT  = 1;
    localparam int CHECK_BIT = 2;
    localparam int CNT_LSB   = 4;
    localparam int TYPE_BIT  = 9;
    localparam int CODE_LSB  = 11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACC,
        ST_STREAM,
        ST_FIN
    } xpa_state_e;

    typedef struct packed {
        logic              fresh;
        logic              emit;
        logic              check;
        logic [CNT_W-1:0]  nsrc;
        logic [CODE_W-1:0] code;
    } xpa_cfg_t;
endpackage

// File: rtl/xpa_req_decode.sv
module xpa_req_decode
    import xpa_pkg::*;
#(
    parameter int MAX_CODE = 4
) (
    input  logic [REQ_W-1:0] word,
    output xpa_cfg_t         cfg,
    output logic             ok
);
    logic unused_bits;

    assign cfg.fresh = word[FRESH_BIT];
    assign cfg.emit  = word[EMIT_BIT];
    assign cfg.check = word[CHECK_BIT];
    assign cfg.nsrc  = word[CNT_LSB +: CNT_W];
    assign cfg.code  = word[CODE_LSB +: CODE_W];

    assign ok = word[TYPE_BIT]
             && (cfg.code <= CODE_W'(MAX_CODE))
             && (cfg.nsrc != '0);

    assign unused_bits = ^{word[REQ_W-1:CODE_LSB+CODE_W], word[TYPE_BIT+1], word[CNT_LSB-1]};
endmodule

// File: rtl/xpa_scratch.sv
module xpa_scratch #(
    parameter int DW    = 32,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/xor_parity_acc.sv
module xor_parity_acc
    import xpa_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MIN_BYTES = 256,
    parameter int MAX_CODE  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_word,
    output logic             req_ready,
    input  logic             src_valid,
    input  logic [DW-1:0]    src_data,
    input  logic             src_last,
    output logic             src_ready,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic             out_last,
    output logic             done,
    output logic [31:0]      status
);
    localparam int BYTES_PER_WORD = DW / 8;
    localparam int BASE_WORDS     = MIN_BYTES / BYTES_PER_WORD;
    localparam int DEPTH          = BASE_WORDS << MAX_CODE;
    localparam int AW             = $clog2(DEPTH);

    typedef struct packed {
        xpa_state_e        state;
        xpa_cfg_t          cfg;
        logic [AW-1:0]     off;
        logic [CNT_W-1:0]  blk;
        logic              nz;
        logic              lerr;
        logic              ovalid;
        logic [DW-1:0]     odata;
        logic              olast;
        logic              done;
        logic [STAT_W-1:0] stat;
    } xpa_regs_t;

    xpa_regs_t     r_d, r_q;
    xpa_cfg_t      dec_cfg;
    logic          dec_ok;
    logic          mem_we;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [AW:0]   word_cnt;
    logic [AW-1:0] word_last;
    logic          final_src, end_word, nz_next, lerr_next;

    xpa_req_decode #(.MAX_CODE(MAX_CODE)) u_dec (
        .word (req_word),
        .cfg  (dec_cfg),
        .ok   (dec_ok)
    );

    xpa_scratch #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (r_q.off),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign word_cnt  = (AW+1)'(BASE_WORDS) << r_q.cfg.code;
    assign word_last = AW'(word_cnt - 1'b1);
    assign final_src = (r_q.blk == r_q.cfg.nsrc - 1'b1);
    assign end_word  = (r_q.off == word_last);

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.ovalid = 1'b0;
        r_d.olast  = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = (r_q.cfg.fresh && r_q.blk == '0) ? src_data : (mem_rdata ^ src_data);
        nz_next    = r_q.nz | (final_src && r_q.cfg.check && mem_wdata != '0);
        lerr_next  = r_q.lerr | (end_word && (src_last != final_src));

        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_ok) begin
                        r_d.state = ST_ACC;
                        r_d.cfg   = dec_cfg;
                        r_d.off   = '0;
                        r_d.blk   = '0;
                        r_d.nz    = 1'b0;
                        r_d.lerr  = 1'b0;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.stat = 3'b100;
                    end
                end
            end
            ST_ACC: begin
                if (src_valid) begin
                    mem_we   = 1'b1;
                    r_d.nz   = nz_next;
                    r_d.lerr = lerr_next;
                    r_d.off  = r_q.off + 1'b1;
                    if (end_word) begin
                        r_d.off = '0;
                        r_d.blk = r_q.blk + 1'b1;
                        if (final_src) begin
                            if (r_q.cfg.emit && !r_q.cfg.check) begin
                                r_d.state = ST_STREAM;
                            end else begin
                                r_d.state = ST_IDLE;
                                r_d.done  = 1'b1;
                                r_d.stat  = {1'b0, lerr_next, nz_next};
                            end
                        end
                    end
                end
            end
            ST_STREAM: begin
                r_d.ovalid = 1'b1;
                r_d.odata  = mem_rdata;
                r_d.olast  = end_word;
                r_d.off    = r_q.off + 1'b1;
                if (end_word) begin
                    r_d.off   = '0;
                    r_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.stat  = {1'b0, r_q.lerr, 1'b0};
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign src_ready = (r_q.state == ST_ACC);
    assign out_valid = r_q.ovalid;
    assign out_data  = r_q.odata;
    assign out_last  = r_q.olast;
    assign done      = r_q.done;
    assign status    = {{(32-STAT_W){1'b0}}, r_q.stat};
endmodule

// File: rtl/xpa_checker.sv
module xpa_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_word,
    input logic        req_ready,
    input logic        src_ready,
    input logic        out_valid,
    input logic        out_last,
    input logic        done,
    input logic [31:0] status
);
    // R9: a request and source words are never taken in the same cycle
    p_single_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && src_ready));

    // R3: parity words only leave while a job is active
    p_out_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    // R3: the final marker travels with a valid word
    p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R8: completion follows the final parity word
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> done);

    // R2: wrong operation type is rejected with the reject bit
    p_reject_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_word[9]) |=> (done && status[2] && !src_ready));
endmodule

bind xor_parity_acc xpa_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_word  (req_word),
    .req_ready (req_ready),
    .src_ready (src_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .done      (done),
    .status    (status)
);

// File: tb/xor_parity_acc_tb_top.sv
module xor_parity_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_word = '0;
    logic        req_ready;
    logic        src_valid = 1'b0;
    logic [31:0] src_data = '0;
    logic        src_last = 1'b0;
    logic        src_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        done;
    logic [31:0] status;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [32:0] exp_out[$];
    logic [31:0] exp_st[$];
    logic [31:0] ref_mem[1024];
    logic        prev_olast = 1'b0;

    always #5 clk = ~clk;

    xor_parity_acc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_ready(req_ready), .src_valid(src_valid), .src_data(src_data),
        .src_last(src_last), .src_ready(src_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .done(done), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock reference comparison of the output stream and the done status
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_olast) chk(done === 1'b1, "R8 done after out_last", {63'b0, done}, 64'd1);
            if (out_valid) begin
                if (exp_out.size() == 0) chk(1'b0, "R3 unexpected output word", {31'b0, out_last, out_data}, 64'd0);
                else begin
                    logic [32:0] e;
                    e = exp_out.pop_front();
                    chk({out_last, out_data} === e, "R3 output word", {31'b0, out_last, out_data}, {31'b0, e});
                end
            end
            if (done) begin
                if (exp_st.size() == 0) chk(1'b0, "R8 unexpected done", {32'b0, status}, 64'd0);
                else begin
                    logic [31:0] s;
                    s = exp_st.pop_front();
                    chk(status === s, "R5 R7 status", {32'b0, status}, {32'b0, s});
                end
            end
            prev_olast = out_valid && out_last;
        end
    end

    function automatic logic [31:0] mkword(bit fresh, bit emit, bit check, int nsrc, int code);
        return 32'(fresh) | (32'(emit) << 1) | (32'(check) << 2) | (32'(nsrc) << 4) | (32'd1 << 9) | (32'(code) << 11);
    endfunction

    // lmode: 0 flag on last source only, 1 also on first source, 2 never
    task automatic job(input string tag, input bit fresh, input bit emit, input bit check,
                       input int nsrc, input int code, input int lmode, input bit cancel, input int seed);
        int w;
        logic [31:0] dat[];
        bit flg[];
        bit nz, lerr, streams;
        w = 64 << code;
        dat = new[nsrc * w];
        flg = new[nsrc];
        nz = 0; lerr = 0;
        streams = emit && !check;
        for (int s = 0; s < nsrc; s++) begin
            flg[s] = (lmode == 0) ? (s == nsrc - 1) : (lmode == 1) ? (s == 0 || s == nsrc - 1) : 1'b0;
            if (flg[s] != (s == nsrc - 1)) lerr = 1;
            for (int i = 0; i < w; i++) begin
                logic [31:0] d;
                d = (seed * 32'h9E3779B1) ^ (32'(s) << 20) ^ (32'(i) * 32'h01000193) ^ 32'(seed + i);
                if (cancel && s == nsrc - 1) d = ref_mem[i];
                dat[s * w + i] = d;
                ref_mem[i] = (fresh && s == 0) ? d : (ref_mem[i] ^ d);
                if (s == nsrc - 1 && check && ref_mem[i] != 0) nz = 1;
            end
        end
        if (streams) for (int i = 0; i < w; i++) exp_out.push_back({i == w - 1, ref_mem[i]});
        exp_st.push_back({29'b0, 1'b0, lerr, nz});
        @(negedge clk);
        req_valid = 1'b1;
        req_word  = mkword(fresh, emit, check, nsrc, code);
        @(negedge clk);
        req_valid = 1'b0;
        chk(src_ready === 1'b1, {"R9 src_ready in job ", tag}, {63'b0, src_ready}, 64'd1);
        for (int s = 0; s < nsrc; s++) begin
            for (int i = 0; i < w; i++) begin
                src_valid = 1'b1;
                src_data  = dat[s * w + i];
                src_last  = flg[s];
                @(negedge clk);
            end
        end
        src_valid = 1'b0;
        src_last  = 1'b0;
        if (!streams) begin
            chk(done === 1'b1, {"R8 done after final word ", tag}, {63'b0, done}, 64'd1);
            chk(out_valid === 1'b0, {"R5 R6 no output ", tag}, {63'b0, out_valid}, 64'd0);
        end else begin
            for (int k = 0; k < w + 4 && !done; k++) @(negedge clk);
        end
        @(negedge clk);
        chk(exp_out.size() == 0, {"R3 all words seen ", tag}, 64'(exp_out.size()), 64'd0);
        chk(exp_st.size() == 0, {"R8 done seen ", tag}, 64'(exp_st.size()), 64'd0);
        chk(req_ready === 1'b1, {"R9 idle after job ", tag}, {63'b0, req_ready}, 64'd1);
    endtask

    task automatic reject(input string tag, input logic [31:0] w);
        exp_st.push_back(32'h4);
        @(negedge clk);
        req_valid = 1'b1;
        req_word  = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done === 1'b1 && status === 32'h4, {"R2 reject ", tag}, {31'b0, done, status}, {31'b0, 1'b1, 32'h4});
        chk(src_ready === 1'b0, {"R2 no source phase ", tag}, {63'b0, src_ready}, 64'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && src_ready === 1'b0 && out_valid === 1'b0 && done === 1'b0,
            "R1 reset state", {60'b0, req_ready, src_ready, out_valid, done}, 64'h8);

        job("enc3",   1, 1, 0, 3, 0, 0, 0, 11);
        job("enc1",   1, 1, 0, 1, 1, 0, 0, 22);
        // R9: words offered while idle must be ignored; R4: continue the scratchpad
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            src_valid = 1'b1;
            src_data  = 32'hDEAD0000 + 32'(k);
        end
        @(negedge clk);
        src_valid = 1'b0;
        job("cont",   0, 1, 0, 2, 1, 0, 0, 33);
        job("valzero",1, 1, 1, 4, 2, 0, 1, 44);
        job("valnz",  1, 0, 1, 2, 0, 0, 0, 55);
        job("noemit", 1, 0, 0, 2, 0, 0, 0, 66);
        job("R7early",1, 1, 0, 3, 0, 1, 0, 77);
        job("R7miss", 1, 0, 1, 2, 0, 2, 1, 88);
        reject("type", mkword(1, 1, 0, 2, 0) & ~(32'd1 << 9));
        reject("code", mkword(1, 1, 0, 2, 5));
        reject("count", mkword(1, 1, 0, 0, 0));
        job("big",    1, 1, 0, 2, 4, 0, 0, 99);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule